// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block keeps an asynchronous EDO-style DRAM with a 16-bit data path alive. It handles three jobs. After reset it waits out a programmed power-up pause. It then fires a burst of wake-up refresh cycles, and only after that does it declare the memory ready. From then on it schedules one distributed CAS-before-RAS (CBR) refresh per row slot of the refresh period. Because every refresh is CBR, the device's internal row counter supplies the address, and the block never drives a row address.

Toward the access arbiter the block offers two signals. `allow_o` is a registered permission level: the arbiter may start an access only in a cycle where it is high. `acc_busy_i` tells the block that an access is still running. A pending refresh waits for that access to finish. It then raises `busy_o`, which keeps access permission withdrawn until RAS precharge is complete. If the gap since the last completed refresh grows past a limit, the next refresh turns into a full wake-up burst. On request the block enters self-refresh through a held CBR cycle, and it leaves with a guarded precharge. All strobe timing is counted in system clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and for the first PAUSE_CYC clocks after reset is released, RAS and both CAS strobes stay high (inactive). In reset, `busy_o`=1 and `allow_o`, `ready_o` and `sr_active_o` are 0.
- R2: After the pause, exactly WAKE_CNT refresh cycles run before `ready_o` rises. `allow_o` is never high before `ready_o` has been high.
- R3: Every refresh is CBR. CAS is low for exactly T_CSR clocks before RAS falls, and RAS is never low while CAS is high.
- R4: In a normal refresh, RAS stays low for max(T_RAS, T_CAS−T_CSR) clocks, so each CAS pulse lasts at least T_CAS. CAS rises together with RAS. At least T_RP clocks of RAS-high precharge come before the next CAS fall.
- R5: With no accesses, consecutive refresh RAS falls are exactly REF_PERIOD_CYC/ROWS clocks apart.
- R6: While `acc_busy_i` is high, no strobe goes low. A pending refresh starts only after the access ends.
- R7: Whenever any strobe is low, `busy_o` is 1 and `allow_o` is 0. `allow_o`=1 implies that all strobes are high.
- R8: When MISS_CYC clocks pass without a completed refresh, the next refresh is a burst of WAKE_CNT CBR cycles. `ready_o` is low for the burst and rises again after it. Under normal traffic `ready_o` does not drop.
- R9: When `sr_req_i` is raised, a CBR cycle starts. RAS then stays low for T_RASS clocks before `sr_active_o` rises. While `sr_active_o` is 1, RAS and CAS stay low.
- R10: After `sr_req_i` falls, all strobes are high for exactly T_RPS clocks before `allow_o` returns.
- R11: CASL and CASH carry identical waveforms at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_busy_i | input | 1 | An access is in progress |
| sr_req_i | input | 1 | Level request to hold the DRAM in self-refresh |
| allow_o | output | 1 | Arbiter may start an access this cycle |
| busy_o | output | 1 | Sequencer owns the DRAM strobes |
| ready_o | output | 1 | Wake-up complete, normal operation |
| sr_active_o | output | 1 | DRAM is held in self-refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| casl_n_o | output | 1 | Low-byte column strobe, active low |
| cash_n_o | output | 1 | High-byte column strobe, active low |

## Verification
The bench targets the edges of the pause and the burst. A design that counted one clock short would pull CAS low early. A design with an off-by-one burst counter would raise `ready_o` after seven or nine cycles. Long held accesses push the refresh gap past MISS_CYC. A design that failed to notice the missed interval would issue only a single refresh, and a design that lost the pending request would skip the refresh entirely. The self-refresh entry and exit windows are measured clock by clock, which exposes a hold that is too short or a precharge that reopens access early. Random access traffic checks that no strobe ever falls during an access and that permission is never granted while a strobe is low.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_WAIT,
    ST_CSR,
    ST_RAS,
    ST_PRE,
    ST_SRH,
    ST_SRS,
    ST_SRX
  } rfs_state_e;
endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
  parameter int unsigned PERIOD = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == W'(PERIOD - 1));
      cnt_q  <= (cnt_q == W'(PERIOD - 1)) ? '0 : cnt_q + W'(1);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rfs_gap.sv
module rfs_gap #(
  parameter int unsigned LIMIT = 6400000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  output logic overdue_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_q <= '0;
    else if (en_i && cnt_q != W'(LIMIT))
      cnt_q <= cnt_q + W'(1);
  end

  assign overdue_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned WAKE_CNT  = 8,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned RAS_HOLD  = 6,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_RASS    = 10000,
  parameter int unsigned T_RPS     = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic overdue_i,
  input  logic acc_busy_i,
  input  logic sr_req_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic allow_o,
  output logic ready_o,
  output logic sr_active_o,
  output logic in_sr_o,
  output logic done_o
);
  localparam int unsigned DW = $clog2(PAUSE_CYC + T_RASS + T_RPS + T_CSR + RAS_HOLD + T_RP + 1);
  localparam int unsigned WW = $clog2(WAKE_CNT + 1);

  rfs_state_e    st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          kind_q, kind_d;   // 1: self-refresh entry
  logic          pend_q, pend_d;
  logic          ready_q, ready_d;
  logic          ras_q, cas_q, busy_q, allow_q, sra_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - DW'(1) : cnt_q;
    wake_d  = wake_q;
    kind_d  = kind_q;
    ready_d = ready_q;
    pend_d  = pend_q | tick_i;
    done_o  = 1'b0;
    unique case (st_q)
      ST_PAUSE: if (cnt_q == '0) begin
        st_d   = ST_CSR;
        cnt_d  = DW'(T_CSR - 1);
        wake_d = WW'(WAKE_CNT);
        kind_d = 1'b0;
      end
      ST_IDLE: if (pend_q || sr_req_i) st_d = ST_WAIT;
      ST_WAIT: if (!acc_busy_i) begin
        if (pend_q) begin
          st_d   = ST_CSR;
          cnt_d  = DW'(T_CSR - 1);
          kind_d = 1'b0;
          pend_d = 1'b0;
          if (overdue_i) begin
            wake_d  = WW'(WAKE_CNT);
            ready_d = 1'b0;
          end
        end else if (sr_req_i) begin
          st_d   = ST_CSR;
          cnt_d  = DW'(T_CSR - 1);
          kind_d = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_CSR: if (cnt_q == '0) begin
        st_d  = kind_q ? ST_SRH : ST_RAS;
        cnt_d = kind_q ? DW'(T_RASS - 1) : DW'(RAS_HOLD - 1);
      end
      ST_RAS: if (cnt_q == '0) begin
        st_d  = ST_PRE;
        cnt_d = DW'(T_RP - 1);
      end
      ST_PRE: if (cnt_q == '0) begin
        done_o = 1'b1;
        if (wake_q > WW'(1)) begin
          wake_d = wake_q - WW'(1);
          st_d   = ST_CSR;
          cnt_d  = DW'(T_CSR - 1);
        end else begin
          wake_d  = '0;
          ready_d = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_SRH: begin
        pend_d = 1'b0;
        if (cnt_q == '0) st_d = ST_SRS;
      end
      ST_SRS: begin
        pend_d = 1'b0;
        if (!sr_req_i) begin
          st_d  = ST_SRX;
          cnt_d = DW'(T_RPS - 1);
        end
      end
      ST_SRX: begin
        pend_d = 1'b0;
        if (cnt_q == '0) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_PAUSE;
      cnt_q   <= DW'(PAUSE_CYC - 1);
      wake_q  <= '0;
      kind_q  <= 1'b0;
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      busy_q  <= 1'b1;
      allow_q <= 1'b0;
      sra_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      wake_q  <= wake_d;
      kind_q  <= kind_d;
      pend_q  <= pend_d;
      ready_q <= ready_d;
      ras_q   <= !(st_d inside {ST_RAS, ST_SRH, ST_SRS});
      cas_q   <= !(st_d inside {ST_CSR, ST_RAS, ST_SRH, ST_SRS});
      busy_q  <= !(st_d inside {ST_IDLE, ST_WAIT});
      allow_q <= (st_d == ST_IDLE) && !pend_d && !sr_req_i;
      sra_q   <= (st_d == ST_SRS);
    end
  end

  assign in_sr_o     = st_q inside {ST_SRH, ST_SRS, ST_SRX};
  assign ras_n_o     = ras_q;
  assign cas_n_o     = cas_q;
  assign busy_o      = busy_q;
  assign allow_o     = allow_q;
  assign ready_o     = ready_q;
  assign sr_active_o = sra_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned PAUSE_CYC      = 20000,
  parameter int unsigned WAKE_CNT       = 8,
  parameter int unsigned REF_PERIOD_CYC = 6400000,
  parameter int unsigned ROWS           = 512,
  parameter int unsigned MISS_CYC       = 6400000,
  parameter int unsigned T_CSR          = 1,
  parameter int unsigned T_RAS          = 6,
  parameter int unsigned T_RP           = 4,
  parameter int unsigned T_CAS          = 2,
  parameter int unsigned T_RASS         = 10000,
  parameter int unsigned T_RPS          = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_busy_i,
  input  logic sr_req_i,
  output logic allow_o,
  output logic busy_o,
  output logic ready_o,
  output logic sr_active_o,
  output logic ras_n_o,
  output logic casl_n_o,
  output logic cash_n_o
);
  localparam int unsigned INTERVAL = REF_PERIOD_CYC / ROWS;
  localparam int unsigned RAS_HOLD = (T_CSR + T_RAS >= T_CAS) ? T_RAS : (T_CAS - T_CSR);

  logic tick, overdue, in_sr, done, cas_n;

  rfs_interval #(.PERIOD(INTERVAL)) u_interval (
    .clk(clk), .rst(rst), .en_i(ready_o && !in_sr), .tick_o(tick)
  );

  rfs_gap #(.LIMIT(MISS_CYC)) u_gap (
    .clk(clk), .rst(rst), .en_i(ready_o && !in_sr), .clr_i(done), .overdue_o(overdue)
  );

  rfs_seq #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_CNT(WAKE_CNT), .T_CSR(T_CSR), .RAS_HOLD(RAS_HOLD),
    .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .overdue_i(overdue),
    .acc_busy_i(acc_busy_i), .sr_req_i(sr_req_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n), .busy_o(busy_o), .allow_o(allow_o),
    .ready_o(ready_o), .sr_active_o(sr_active_o), .in_sr_o(in_sr), .done_o(done)
  );

  assign casl_n_o = cas_n;
  assign cash_n_o = cas_n;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned PAUSE_CYC = 20000
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic casl_n,
  input logic allow,
  input logic busy,
  input logic sr_active
);
  logic [31:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 32'd1;
  end

  a_r1_quiet_pause: assert property (@(posedge clk) disable iff (rst)
    (since_q < PAUSE_CYC) |-> (ras_n && casl_n));

  a_r3_no_ras_only: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !casl_n);

  a_r3_cas_leads: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> !$past(casl_n));

  a_r7_allow_quiet: assert property (@(posedge clk) disable iff (rst)
    allow |-> (ras_n && casl_n && !busy));

  a_r7_busy_cover: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !casl_n) |-> busy);

  a_r9_sr_hold: assert property (@(posedge clk) disable iff (rst)
    sr_active |-> (!ras_n && !casl_n));
endmodule

bind dram_refresh_seq rfs_checker #(.PAUSE_CYC(PAUSE_CYC)) u_rfs_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n_o), .casl_n(casl_n_o),
  .allow(allow_o), .busy(busy_o), .sr_active(sr_active_o)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int unsigned PAUSE_CYC = 300;
  localparam int unsigned WAKE_CNT  = 8;
  localparam int unsigned ROWS      = 512;
  localparam int unsigned REF_PER   = 512 * 200;
  localparam int unsigned MISS_CYC  = 600;
  localparam int unsigned T_CSR     = 2;
  localparam int unsigned T_RAS     = 5;
  localparam int unsigned T_RP      = 3;
  localparam int unsigned T_CAS     = 9;
  localparam int unsigned T_RASS    = 20;
  localparam int unsigned T_RPS     = 6;

  function automatic int interval_len();
    return REF_PER / ROWS;
  endfunction
  function automatic int ras_len();
    return (T_CSR + T_RAS >= T_CAS) ? T_RAS : T_CAS - T_CSR;
  endfunction

  logic clk = 0, rst = 1, acc_busy = 0, sr_req = 0;
  logic allow, busy, ready, sr_act, ras_n, casl_n, cash_n;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_CNT(WAKE_CNT), .REF_PERIOD_CYC(REF_PER), .ROWS(ROWS),
    .MISS_CYC(MISS_CYC), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_CAS(T_CAS),
    .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) i_dram_refresh_seq (
    .clk(clk), .rst(rst), .acc_busy_i(acc_busy), .sr_req_i(sr_req),
    .allow_o(allow), .busy_o(busy), .ready_o(ready), .sr_active_o(sr_act),
    .ras_n_o(ras_n), .casl_n_o(casl_n), .cash_n_o(cash_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  longint edge_cnt = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) edge_cnt <= 0; else edge_cnt <= edge_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // strobe monitor
  int  ras_low_run = 0, ras_high_run = 0, cas_low_run = 0, n_fall = 0;
  longint last_fall_t = 0, first_cas = -1;
  bit  prev_ras = 1, prev_cas = 1, have_rise = 0, seen_ready = 0, early_allow = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(casl_n == cash_n, "R11", casl_n, cash_n);
      if (acc_busy) chk(ras_n && casl_n, "R6", {ras_n, casl_n}, 3);
      if (!ras_n || !casl_n) chk(busy && !allow, "R7", {busy, allow}, 2);
      if (!ras_n) chk(!casl_n, "R3", casl_n, 0);
      if (ready) seen_ready = 1;
      if (allow && !seen_ready) early_allow = 1;
      if (!casl_n && first_cas < 0) first_cas = edge_cnt;
      if (prev_ras && !ras_n) begin
        chk(cas_low_run == T_CSR, "R3", cas_low_run, T_CSR);
        n_fall++;
        last_fall_t = edge_cnt;
      end
      if (!prev_ras && ras_n) begin
        if (ras_low_run < T_RASS) begin
          chk(ras_low_run == ras_len(), "R4", ras_low_run, ras_len());
          chk(casl_n && cas_low_run == T_CSR + ras_len(), "R4", cas_low_run, T_CSR + ras_len());
        end
        have_rise = 1;
      end
      if (prev_cas && !casl_n && have_rise)
        chk(ras_high_run >= T_RP, "R4", ras_high_run, T_RP);
      ras_low_run  = !ras_n  ? ras_low_run + 1  : 0;
      ras_high_run = ras_n   ? ras_high_run + 1 : 0;
      cas_low_run  = !casl_n ? cas_low_run + 1  : 0;
      prev_ras = ras_n;
      prev_cas = casl_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_fall(output longint t);
    int n;
    n = n_fall;
    while (n_fall == n) step();
    t = last_fall_t;
  endtask

  initial begin
    longint t0, t1, t2;
    int n0, cnt, len;
    bit active, bad, dropped;
    void'($urandom(32'd2024));
    repeat (4) step();
    chk(ras_n && casl_n && cash_n, "R1", {ras_n, casl_n, cash_n}, 7);
    chk(busy && !allow && !ready && !sr_act, "R1", {busy, allow, ready, sr_act}, 8);
    rst = 0;

    while (!ready) step();
    chk(n_fall == WAKE_CNT, "R2", n_fall, WAKE_CNT);
    chk(first_cas >= PAUSE_CYC, "R1", first_cas, PAUSE_CYC);
    chk(!early_allow, "R2", early_allow, 0);

    wait_fall(t0); wait_fall(t1); wait_fall(t2);
    chk(t1 - t0 == interval_len(), "R5", t1 - t0, interval_len());
    chk(t2 - t1 == interval_len(), "R5", t2 - t1, interval_len());

    // random accesses
    active = 0; len = 0; dropped = 0; n0 = n_fall;
    for (int i = 0; i < 6000; i++) begin
      step();
      if (!ready) dropped = 1;
      if (active) begin
        len--;
        if (len == 0) begin acc_busy = 0; active = 0; end
      end else if (allow && ($urandom % 4 == 0)) begin
        acc_busy = 1; active = 1;
        len = 1 + int'($urandom % (interval_len() / 2));
      end
    end
    while (active) begin
      step(); len--;
      if (len == 0) begin acc_busy = 0; active = 0; end
    end
    chk(!dropped, "R8", dropped, 0);
    cnt = 6000 / (interval_len() + interval_len() / 2 + 30) - 1;
    chk(n_fall - n0 >= cnt, "R5", n_fall - n0, cnt);

    // missed interval -> full wake-up burst
    while (!allow) step();
    acc_busy = 1;
    n0 = n_fall;
    repeat (MISS_CYC + interval_len()) step();
    chk(n_fall == n0, "R6", n_fall - n0, 0);
    acc_busy = 0;
    while (ready) step();
    chk(!ready, "R8", ready, 0);
    while (!ready) step();
    chk(n_fall - n0 == WAKE_CNT, "R8", n_fall - n0, WAKE_CNT);

    // self-refresh entry
    while (!allow) step();
    sr_req = 1;
    cnt = 0;
    forever begin
      step();
      if (sr_act) break;
      cnt = !ras_n ? cnt + 1 : 0;
    end
    chk(cnt == T_RASS, "R9", cnt, T_RASS);
    bad = 0;
    repeat (40) begin
      step();
      if (ras_n || casl_n || !sr_act || allow) bad = 1;
    end
    chk(!bad, "R9", bad, 0);

    // self-refresh exit
    sr_req = 0;
    cnt = 0; bad = 0;
    forever begin
      step();
      if (allow) break;
      if (!ras_n || !casl_n) bad = 1;
      cnt++;
    end
    chk(cnt == T_RPS, "R10", cnt, T_RPS);
    chk(!bad && !sr_act, "R10", bad, 0);

    wait_fall(t0);
    chk(ready, "R5", ready, 1);
    repeat (5) step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule